// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block sits next to a small processor core and decides how far the chip powers down when the core executes its sleep operation. The core presents a 3-bit mode code, a sleep-enable bit and a one-cycle sleep strobe. The block then drops the clock enables that the chosen mode turns off. Six enable outputs cover the CPU, the flash, I/O, the ADC, the asynchronous timer and the main oscillator. The block keeps a per-mode mask of the wake requests that may end the sleep.

When an allowed request arrives, the block restores the clocks. In Idle and ADC noise reduction the oscillator never stopped, so the clocks return at once. In power-down and power-save the oscillator is re-enabled first. The other domains are then held off for a programmable start-up delay, counted in slow-clock ticks. A one-cycle wake-complete pulse marks the return of the clocks to the core.

Two more rules apply. Entering Idle or ADC noise reduction with the ADC enabled fires a one-cycle conversion-start pulse. Level requests on the upper external lines pass a synchronizer and a hold filter before they count as wake sources.

Top module: `sleep_pwr_ctrl`

## Requirements
- R1: While reset is held, and after it is released until the first sleep entry, all six clock enables are 1, and adc_start and wake_done are 0.
- R2: The cycle after an accepted sleep strobe, the clock enables {cpu,flash,io,adc,asy,osc} take the following values:
  - mode 0 gives 001111;
  - mode 1 gives 000111;
  - mode 2 gives 000000;
  - mode 3 gives 0000A0, where A is async_sel sampled at the strobe.
- R3: A sleep strobe has no effect if sleep_en is 0 or mode_sel is 4 to 7. In that case the clocks stay on and no wake_done pulse follows.
- R4: In mode 0 any of the following ends the sleep:
  - a reset-type event (xrst_evt, wdt_evt, bor_evt);
  - an enabled external line;
  - twi_match, adc_done, ee_rdy or misc_irq;
  - a timer 0 overflow or compare that has its own enable set.
- R5: In mode 1 the allowed sources are the same as in mode 0 except that misc_irq is ignored.
- R6: In mode 2 only reset-type events, enabled external lines and twi_match wake. adc_done, ee_rdy, misc_irq and timer 0 events are ignored.
- R7: Mode 3 wakes like mode 2. In addition, a timer 0 overflow or compare wakes it when all three of the following hold:
  - async_sel was 1 at entry;
  - gie is 1;
  - the event's own enable is 1.
- R8: Entry into mode 0 or 1 with adc_en=1 gives adc_start=1 for exactly the one cycle after the strobe. Entry into mode 2 or 3, or with adc_en=0, gives no pulse.
- R9: On a wake from mode 2 or 3, osc_en returns at once while the other gated enables stay off. The remaining enables return after N slow_tick cycles, where delay_sel 0,1,2,3 gives N = 16, 256, 1024, 4096.
- R10: wake_done is a single-cycle pulse that coincides with the first cycle of restored clocks. In modes 0 and 1 this is the cycle after the wake request is sampled.
- R11: An upper external line (ext_hi_lvl) wakes only after a 3-stage synchronizer has seen it high on 4 consecutive samples. A level held for 3 cycles never wakes, and one held for 10 cycles does.
- R12: If a request allowed in the selected mode is already present at the strobe, the clocks are never gated. wake_done pulses the next cycle. A pending request that the mode does not allow does not prevent sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_strobe | input | 1 | One-cycle sleep request from the core |
| sleep_en | input | 1 | Sleep permitted |
| mode_sel | input | 3 | Sleep mode code |
| async_sel | input | 1 | Timer 0 runs from the asynchronous clock |
| adc_en | input | 1 | ADC is enabled |
| gie | input | 1 | Global interrupt enable |
| t0_ovf_ie | input | 1 | Timer 0 overflow interrupt enable |
| t0_cmp_ie | input | 1 | Timer 0 compare interrupt enable |
| ext_ie | input | 8 | External line enables, [3:0] lower, [7:4] upper |
| ext_lo_req | input | 4 | Lower external line interrupt requests |
| ext_hi_lvl | input | 4 | Upper external line levels (active high) |
| twi_match | input | 1 | Two-wire address match |
| wdt_evt | input | 1 | Watchdog event |
| bor_evt | input | 1 | Brown-out event |
| xrst_evt | input | 1 | External reset event |
| t0_ovf | input | 1 | Timer 0 overflow |
| t0_cmp | input | 1 | Timer 0 compare match |
| adc_done | input | 1 | ADC conversion complete |
| ee_rdy | input | 1 | EEPROM / program-memory ready |
| misc_irq | input | 1 | Any other enabled internal interrupt |
| delay_sel | input | 2 | Start-up delay select |
| slow_tick | input | 1 | One-cycle tick of the slow clock |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_flash | output | 1 | Flash clock enable |
| clk_en_io | output | 1 | I/O clock enable |
| clk_en_adc | output | 1 | ADC clock enable |
| clk_en_asy | output | 1 | Asynchronous timer clock enable |
| osc_en | output | 1 | Main oscillator enable |
| adc_start | output | 1 | ADC conversion start pulse |
| wake_done | output | 1 | Clocks returned to the core |

## Verification
The strobe that enters sleep and a wake request can arrive in the same cycle. In that case the block must skip gating altogether rather than dip the clocks for one cycle. The bench provokes this by holding twi_match high while strobing mode 2. The next cycle must show osc_en and clk_en_cpu still at 1 with a wake_done pulse. The bench then repeats the strobe with only a source that mode 2 does not allow held high, and requires the clocks to drop.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

  localparam logic [2:0] SM_IDLE  = 3'd0;
  localparam logic [2:0] SM_ADCNR = 3'd1;
  localparam logic [2:0] SM_PDOWN = 3'd2;
  localparam logic [2:0] SM_PSAVE = 3'd3;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_START = 2'd2
  } pwr_state_e;

  typedef struct packed {
    logic cpu;
    logic flash;
    logic io;
    logic adc;
    logic asy;
    logic osc;
  } clk_gate_t;

  typedef struct packed {
    logic xrst;
    logic wdt;
    logic bor;
    logic twi;
    logic adc_done;
    logic ee_rdy;
    logic t0_ovf;
    logic t0_cmp;
    logic misc;
  } wake_src_t;

  localparam clk_gate_t GATE_ALL_ON = '{cpu: 1'b1, flash: 1'b1, io: 1'b1,
                                        adc: 1'b1, asy: 1'b1, osc: 1'b1};

  function automatic clk_gate_t gate_for(input logic [2:0] m, input logic as_sel);
    clk_gate_t g;
    g = GATE_ALL_ON;
    case (m)
      SM_IDLE:  begin g.cpu = 1'b0; g.flash = 1'b0; end
      SM_ADCNR: begin g.cpu = 1'b0; g.flash = 1'b0; g.io = 1'b0; end
      SM_PDOWN: g = '0;
      SM_PSAVE: begin g = '0; g.asy = as_sel; end
      default:  g = GATE_ALL_ON;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/lvl_filter.sv
module lvl_filter #(
  parameter int SYNC_STAGES = 3,
  parameter int HOLD        = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_in,
  output logic lvl_ok
);
  localparam int CW = $clog2(HOLD + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '0;
      run_cnt <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], lvl_in};
      if (!sync_q[SYNC_STAGES-1])
        run_cnt <= '0;
      else if (run_cnt != CW'(HOLD))
        run_cnt <= run_cnt + 1'b1;
    end
  end

  assign lvl_ok = (run_cnt == CW'(HOLD));
endmodule

// File: rtl/wake_mask.sv
module wake_mask
  import sleep_pkg::*;
#(
  parameter int NUM_LO = 4,
  parameter int NUM_HI = 4
) (
  input  logic [2:0]             mode,
  input  logic                   as_sel,
  input  logic                   gie,
  input  logic                   ovf_ie,
  input  logic                   cmp_ie,
  input  logic [NUM_LO+NUM_HI-1:0] ext_ie,
  input  logic [NUM_LO-1:0]      lo_req,
  input  logic [NUM_HI-1:0]      hi_req,
  input  wake_src_t              src,
  output logic                   wake
);
  logic rst_any, ext_any, t0_any;

  always_comb begin
    rst_any = src.xrst | src.wdt | src.bor;
    ext_any = (|(lo_req & ext_ie[NUM_LO-1:0])) |
              (|(hi_req & ext_ie[NUM_LO+NUM_HI-1:NUM_LO]));
    t0_any  = (src.t0_ovf & ovf_ie) | (src.t0_cmp & cmp_ie);
    case (mode)
      SM_IDLE:  wake = rst_any | ext_any | src.twi | src.adc_done |
                       src.ee_rdy | t0_any | src.misc;
      SM_ADCNR: wake = rst_any | ext_any | src.twi | src.adc_done |
                       src.ee_rdy | t0_any;
      SM_PDOWN: wake = rst_any | ext_any | src.twi;
      SM_PSAVE: wake = rst_any | ext_any | src.twi | (as_sel & gie & t0_any);
      default:  wake = 1'b0;
    endcase
  end
endmodule

// File: rtl/startup_timer.sv
module startup_timer #(
  parameter int CNT_W = 13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [1:0] sel,
  input  logic       tick,
  output logic       expire
);
  logic [CNT_W-1:0] cnt;
  logic             active;
  int unsigned      sh;

  always_comb begin
    case (sel)
      2'd0:    sh = 4;
      2'd1:    sh = 8;
      2'd2:    sh = 10;
      default: sh = 12;
    endcase
  end

  assign expire = active && tick && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt    <= CNT_W'(1) << sh;
      active <= 1'b1;
    end else if (active && tick) begin
      cnt <= cnt - 1'b1;
      if (cnt == CNT_W'(1))
        active <= 1'b0;
    end
  end
endmodule

// File: rtl/sleep_pwr_ctrl.sv
module sleep_pwr_ctrl
  import sleep_pkg::*;
#(
  parameter int NUM_LO      = 4,
  parameter int NUM_HI      = 4,
  parameter int SYNC_STAGES = 3,
  parameter int LVL_HOLD    = 4,
  parameter int DLY_W       = 13
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sleep_strobe,
  input  logic                     sleep_en,
  input  logic [2:0]               mode_sel,
  input  logic                     async_sel,
  input  logic                     adc_en,
  input  logic                     gie,
  input  logic                     t0_ovf_ie,
  input  logic                     t0_cmp_ie,
  input  logic [NUM_LO+NUM_HI-1:0] ext_ie,
  input  logic [NUM_LO-1:0]        ext_lo_req,
  input  logic [NUM_HI-1:0]        ext_hi_lvl,
  input  logic                     twi_match,
  input  logic                     wdt_evt,
  input  logic                     bor_evt,
  input  logic                     xrst_evt,
  input  logic                     t0_ovf,
  input  logic                     t0_cmp,
  input  logic                     adc_done,
  input  logic                     ee_rdy,
  input  logic                     misc_irq,
  input  logic [1:0]               delay_sel,
  input  logic                     slow_tick,
  output logic                     clk_en_cpu,
  output logic                     clk_en_flash,
  output logic                     clk_en_io,
  output logic                     clk_en_adc,
  output logic                     clk_en_asy,
  output logic                     osc_en,
  output logic                     adc_start,
  output logic                     wake_done
);
  pwr_state_e        state;
  clk_gate_t         gate;
  logic [2:0]        cur_mode;
  logic              cur_async;
  logic              adc_start_q, wake_done_q;
  logic [NUM_HI-1:0] hi_ok;
  wake_src_t         src;
  logic              wake_live, wake_held, tmr_expire, tmr_load;
  logic              accept;

  for (genvar i = 0; i < NUM_HI; i++) begin : g_hi
    lvl_filter #(.SYNC_STAGES(SYNC_STAGES), .HOLD(LVL_HOLD)) u_flt (
      .clk(clk), .rst(rst), .lvl_in(ext_hi_lvl[i]), .lvl_ok(hi_ok[i])
    );
  end

  assign src = '{xrst: xrst_evt, wdt: wdt_evt, bor: bor_evt, twi: twi_match,
                 adc_done: adc_done, ee_rdy: ee_rdy, t0_ovf: t0_ovf,
                 t0_cmp: t0_cmp, misc: misc_irq};

  wake_mask #(.NUM_LO(NUM_LO), .NUM_HI(NUM_HI)) u_mask_live (
    .mode(mode_sel), .as_sel(async_sel), .gie(gie), .ovf_ie(t0_ovf_ie),
    .cmp_ie(t0_cmp_ie), .ext_ie(ext_ie), .lo_req(ext_lo_req), .hi_req(hi_ok),
    .src(src), .wake(wake_live)
  );

  wake_mask #(.NUM_LO(NUM_LO), .NUM_HI(NUM_HI)) u_mask_held (
    .mode(cur_mode), .as_sel(cur_async), .gie(gie), .ovf_ie(t0_ovf_ie),
    .cmp_ie(t0_cmp_ie), .ext_ie(ext_ie), .lo_req(ext_lo_req), .hi_req(hi_ok),
    .src(src), .wake(wake_held)
  );

  assign accept   = sleep_strobe && sleep_en && !mode_sel[2];
  assign tmr_load = (state == ST_SLEEP) && wake_held && cur_mode[1];

  startup_timer #(.CNT_W(DLY_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .sel(delay_sel),
    .tick(slow_tick), .expire(tmr_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_RUN;
      gate        <= GATE_ALL_ON;
      cur_mode    <= SM_IDLE;
      cur_async   <= 1'b0;
      adc_start_q <= 1'b0;
      wake_done_q <= 1'b0;
    end else begin
      adc_start_q <= 1'b0;
      wake_done_q <= 1'b0;
      case (state)
        ST_RUN: begin
          if (accept) begin
            if (wake_live) begin
              wake_done_q <= 1'b1;
            end else begin
              state       <= ST_SLEEP;
              cur_mode    <= mode_sel;
              cur_async   <= async_sel;
              gate        <= gate_for(mode_sel, async_sel);
              adc_start_q <= adc_en && !mode_sel[1];
            end
          end
        end
        ST_SLEEP: begin
          if (wake_held) begin
            if (cur_mode[1]) begin
              state    <= ST_START;
              gate.osc <= 1'b1;
            end else begin
              state       <= ST_RUN;
              gate        <= GATE_ALL_ON;
              wake_done_q <= 1'b1;
            end
          end
        end
        ST_START: begin
          if (tmr_expire) begin
            state       <= ST_RUN;
            gate        <= GATE_ALL_ON;
            wake_done_q <= 1'b1;
          end
        end
        default: begin
          state <= ST_RUN;
          gate  <= GATE_ALL_ON;
        end
      endcase
    end
  end

  assign clk_en_cpu   = gate.cpu;
  assign clk_en_flash = gate.flash;
  assign clk_en_io    = gate.io;
  assign clk_en_adc   = gate.adc;
  assign clk_en_asy   = gate.asy;
  assign osc_en       = gate.osc;
  assign adc_start    = adc_start_q;
  assign wake_done    = wake_done_q;
endmodule

// File: rtl/sleep_pwr_chk.sv
module sleep_pwr_chk (
  input logic       clk,
  input logic       rst,
  input logic       sleep_strobe,
  input logic       sleep_en,
  input logic [2:0] mode_sel,
  input logic       clk_en_cpu,
  input logic       clk_en_flash,
  input logic       clk_en_io,
  input logic       clk_en_adc,
  input logic       osc_en,
  input logic       adc_start,
  input logic       wake_done
);
  AST_ADC_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start); // R8
  AST_ADC_PULSE_GATED: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> (!clk_en_cpu && clk_en_adc)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wake_done |=> !wake_done); // R10
  AST_DONE_CLOCKS_ON: assert property (@(posedge clk) disable iff (rst)
    wake_done |-> (clk_en_cpu && clk_en_flash && clk_en_io && osc_en)); // R10
  AST_OSC_OFF_CPU_OFF: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> !clk_en_cpu); // R2
  AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (sleep_strobe && mode_sel[2] && clk_en_cpu) |=> clk_en_cpu); // R3
  AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (sleep_strobe && !sleep_en && clk_en_cpu) |=> clk_en_cpu); // R3
  AST_OSC_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_en) |-> !clk_en_cpu); // R9
endmodule

bind sleep_pwr_ctrl sleep_pwr_chk u_chk (.*);

// File: tb/tb_sleep_pwr_ctrl.sv
module tb_sleep_pwr_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_strobe = 0, sleep_en = 0, async_sel = 0, adc_en = 0, gie = 1;
  logic t0_ovf_ie = 1, t0_cmp_ie = 1;
  logic [2:0] mode_sel = 0;
  logic [7:0] ext_ie = 8'hFF;
  logic [3:0] ext_lo_req = 0, ext_hi_lvl = 0;
  logic twi_match = 0, wdt_evt = 0, bor_evt = 0, xrst_evt = 0;
  logic t0_ovf = 0, t0_cmp = 0, adc_done = 0, ee_rdy = 0, misc_irq = 0;
  logic [1:0] delay_sel = 0;
  logic slow_tick = 1;
  logic clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, clk_en_asy, osc_en;
  logic adc_start, wake_done;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sleep_pwr_ctrl dut (.*);

  // vector: {mode[3], async[1], source[4], expect_wake[1]}
  // sources: 0 xrst 1 wdt 2 bor 3 twi 4 adc_done 5 ee_rdy 6 t0_ovf 7 t0_cmp 8 ext_lo[0] 9 misc
  localparam int NV = 17;
  localparam logic [8:0] VEC [NV] = '{
    {3'd0, 1'b0, 4'd9, 1'b1}, {3'd0, 1'b0, 4'd6, 1'b1}, {3'd0, 1'b0, 4'd5, 1'b1},
    {3'd1, 1'b0, 4'd4, 1'b1}, {3'd1, 1'b0, 4'd9, 1'b0}, {3'd1, 1'b0, 4'd5, 1'b1},
    {3'd1, 1'b0, 4'd7, 1'b1}, {3'd1, 1'b0, 4'd8, 1'b1},
    {3'd2, 1'b0, 4'd1, 1'b1}, {3'd2, 1'b0, 4'd4, 1'b0}, {3'd2, 1'b0, 4'd6, 1'b0},
    {3'd2, 1'b0, 4'd3, 1'b1}, {3'd2, 1'b0, 4'd5, 1'b0},
    {3'd3, 1'b0, 4'd6, 1'b0}, {3'd3, 1'b1, 4'd6, 1'b1}, {3'd3, 1'b1, 4'd7, 1'b1},
    {3'd3, 1'b1, 4'd4, 1'b0}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_gate(input logic [2:0] m, input logic a);
    case (m)
      3'd0: return 6'b001111;
      3'd1: return 6'b000111;
      3'd2: return 6'b000000;
      default: return {4'b0000, a, 1'b0};
    endcase
  endfunction

  function automatic logic [5:0] gates();
    return {clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, clk_en_asy, osc_en};
  endfunction

  task automatic set_src(input int s, input logic v);
    case (s)
      0: xrst_evt = v;  1: wdt_evt = v;  2: bor_evt = v;  3: twi_match = v;
      4: adc_done = v;  5: ee_rdy = v;   6: t0_ovf = v;   7: t0_cmp = v;
      8: ext_lo_req[0] = v;
      default: misc_irq = v;
    endcase
  endtask

  task automatic enter(input logic [2:0] m, input logic a);
    mode_sel = m; async_sel = a; sleep_en = 1; sleep_strobe = 1;
    tick();
    sleep_strobe = 0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 6000; k++) begin
      if (wake_done) break;
      tick();
    end
  endtask

  task automatic force_wake();
    xrst_evt = 1; tick(); xrst_evt = 0;
    wait_done(); tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    logic woke;
    repeat (3) tick();
    chk("R1 enables in reset", {26'd0, gates()}, 32'h3F);
    chk("R1 pulses in reset", {30'd0, adc_start, wake_done}, 0);
    rst = 0;
    tick();
    chk("R1 enables after reset", {26'd0, gates()}, 32'h3F);

    // table walk
    for (int i = 0; i < NV; i++) begin
      enter(VEC[i][8:6], VEC[i][5]);
      chk($sformatf("R2 gating vec %0d", i), {26'd0, gates()},
          {26'd0, exp_gate(VEC[i][8:6], VEC[i][5])});
      set_src(int'(VEC[i][4:1]), 1); tick(); set_src(int'(VEC[i][4:1]), 0);
      woke = (VEC[i][8:6] < 3'd2) ? wake_done : osc_en;
      chk($sformatf("R4 R5 R6 R7 wake vec %0d mode %0d", i, VEC[i][8:6]),
          {31'd0, woke}, {31'd0, VEC[i][0]});
      if (!woke) begin xrst_evt = 1; tick(); xrst_evt = 0; end
      wait_done(); tick();
    end

    // R3: sleep_en low and reserved code ignored
    sleep_en = 0; mode_sel = 0; sleep_strobe = 1; tick(); sleep_strobe = 0;
    chk("R3 sleep_en=0 ignored", {26'd0, gates(), wake_done}, {25'd0, 7'b1111110});
    sleep_en = 1; mode_sel = 3'd6; sleep_strobe = 1; tick(); sleep_strobe = 0;
    chk("R3 reserved mode ignored", {26'd0, gates(), wake_done}, {25'd0, 7'b1111110});
    tick();
    chk("R3 reserved mode no later effect", {26'd0, gates(), wake_done}, {25'd0, 7'b1111110});

    // R8: adc start pulse
    adc_en = 1;
    enter(3'd1, 0);
    chk("R8 adc_start on mode1 entry", {31'd0, adc_start}, 1);
    tick();
    chk("R8 adc_start one cycle", {31'd0, adc_start}, 0);
    adc_done = 1; tick(); adc_done = 0;
    chk("R10 wake_done after adc_done", {31'd0, wake_done}, 1);
    tick();
    chk("R10 wake_done single cycle", {31'd0, wake_done}, 0);
    enter(3'd2, 0);
    chk("R8 no adc_start in mode2", {31'd0, adc_start}, 0);
    force_wake();
    adc_en = 0;
    enter(3'd0, 0);
    chk("R8 no adc_start with adc_en=0", {31'd0, adc_start}, 0);
    force_wake();

    // R12: immediate return vs disallowed pending source
    twi_match = 1;
    enter(3'd2, 0);
    chk("R12 pending twi no gating", {26'd0, gates(), wake_done}, {25'd0, 7'b1111111});
    twi_match = 0; tick();
    misc_irq = 1;
    enter(3'd2, 0);
    chk("R12 disallowed pending still sleeps", {31'd0, osc_en}, 0);
    misc_irq = 0;
    force_wake();

    // R7: power-save with gie low
    gie = 0;
    enter(3'd3, 1);
    t0_ovf = 1; tick(); t0_ovf = 0;
    chk("R7 gie=0 blocks timer wake", {31'd0, osc_en}, 0);
    gie = 1;
    force_wake();

    // R9: start-up delay
    for (int s = 0; s < 2; s++) begin
      delay_sel = 2'(s);
      enter(3'd2, 0);
      wdt_evt = 1; tick(); wdt_evt = 0;
      chk("R9 oscillator first", {30'd0, osc_en, clk_en_cpu}, 2'b10);
      n = 0;
      for (int k = 0; k < 6000; k++) begin
        tick(); n++;
        if (wake_done) break;
      end
      chk($sformatf("R9 delay_sel %0d ticks", s), n, (s == 0) ? 16 : 256);
      chk("R9 clocks back", {26'd0, gates()}, 32'h3F);
      tick();
    end
    delay_sel = 0;

    // R11: level filter
    enter(3'd2, 0);
    ext_hi_lvl[0] = 1; repeat (3) tick(); ext_hi_lvl[0] = 0;
    repeat (10) tick();
    chk("R11 short level ignored", {31'd0, osc_en}, 0);
    ext_hi_lvl[0] = 1; repeat (10) tick(); ext_hi_lvl[0] = 0;
    chk("R11 held level wakes", {31'd0, osc_en}, 1);
    wait_done(); tick();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule